// File: doc/BRIEF.md
# PSRAM Sleep-Mode and Configuration Controller

This block holds the low-power control of a pseudo-static RAM. It watches an active-low sleep pin. When that pin stays low long enough while the device is idle, the block puts the device into one of two low-power states. A select bit in an internal configuration register picks the state. The first is a partial-refresh sleep, which ends at once when the pin returns high. The second is a deep power-down, in which refresh stops and the stored contents are lost. After a deep power-down the device must complete a long initialization wait before it can be used again.

The same pin also opens a configuration load. The first write that follows a falling edge of the sleep pin, while the device is in standby, takes its 22 address bits as the new register value. The value is captured when either strobe returns high, whichever does so first. A completed load cancels the sleep request that the falling edge had started.

All pins are treated as synchronous to `clk`. The two low-power timings are parameters given in clock cycles: `SLEEP_CYCLES` for the low time needed to enter a sleep state, and `INIT_CYCLES` for the initialization wait.

Top module: `psram_sleep_ctrl`

## Requirements
- R1: After reset, `cfg_q` equals `CFG_RESET`, `mode` is standby (2'b00), `access_en` is 1 and `data_lost` is 0.
- R2: A sleep state is entered only on the clock edge at which `zz_n` has been sampled low on `SLEEP_CYCLES` consecutive edges while in standby. A shorter low pulse leaves the mode at standby.
- R3: The sleep state taken depends on `cfg_q[4]`. A value of 1 enters partial refresh (`mode` 2'b01), and a value of 0 enters deep power-down (`mode` 2'b10).
- R4: `access_en` is 1 only in standby. It is 0 in partial refresh, in deep power-down and in initializing (`mode` 2'b11).
- R5: From partial refresh, a high sample of `zz_n` returns `mode` to standby on that same edge, with no wait.
- R6: From deep power-down, a high sample of `zz_n` moves to initializing. The mode stays there for `INIT_CYCLES` edges and then returns to standby.
- R7: `data_lost` rises when deep power-down is entered. It stays high through initializing and back into standby, and it clears at the first edge at which a write (`ce_n` and `we_n` both low) is sampled in standby.
- R8: The first write that completes after a falling edge of `zz_n` in standby, with `zz_n` still low, loads `addr` into `cfg_q`. The value is taken at the edge where `ce_n` or `we_n` is first seen high again.
- R9: A configuration load cancels the pending sleep entry. No sleep state is entered until `zz_n` has gone high again. When a load completes on the same edge as the sleep timer expiry, the load wins and the mode stays at standby.
- R10: `cfg_q` does not change outside of R8. A write while asleep, a second write after a load, and a write with no preceding `zz_n` fall all leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zz_n | input | 1 | Active-low sleep request pin |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 22 | Address bus, the configuration value during a load |
| cfg_q | output | 22 | Configuration register value |
| mode | output | 2 | 00 standby, 01 partial refresh, 10 deep power-down, 11 initializing |
| access_en | output | 1 | High when reads and writes are accepted |
| data_lost | output | 1 | Stored contents are invalid after a deep power-down |

## Verification
The configuration load and the sleep-timer expiry can land on the same edge. The bench provokes this by lowering `zz_n`, holding a write low, and raising `we_n` exactly when the low-time count reaches its limit. It then expects the new register value together with an unchanged standby mode, and it checks that standby holds for several more cycles. A scoreboard queue carries every expected mode, register value and flag, and it is compared on the falling clock edge after each stimulus step.

// File: rtl/psram_lp_pkg.sv
// Package: shared mode encoding for the PSRAM low-power controller.
// Assumes: the encoding is visible at the top-level mode port.
package psram_lp_pkg;
    typedef enum logic [1:0] {
        LP_STBY = 2'b00,
        LP_PAR  = 2'b01,
        LP_DPD  = 2'b10,
        LP_INIT = 2'b11
    } lp_mode_e;
endpackage

// File: rtl/lp_pin_sense.sv
// Module: registers the sleep pin and the write strobes, and produces
// edge events from them.
// Assumes: the pins are already synchronous to clk.
module lp_pin_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic zz_n,
    input  logic ce_n,
    input  logic we_n,
    output logic zz_fall,
    output logic wr_now,
    output logic wr_end
);
    logic zz_q;
    logic wr_q;

    assign wr_now  = !ce_n && !we_n;
    assign zz_fall = zz_q && !zz_n;
    assign wr_end  = wr_q && (ce_n || we_n);

    // Keep the previous-cycle pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zz_q <= 1'b1;
            wr_q <= 1'b0;
        end else begin
            zz_q <= zz_n;
            wr_q <= wr_now;
        end
    end
endmodule

// File: rtl/lp_cycle_timer.sv
// Module: counts the cycles that run stays high. done rises on the
// LIMIT-th consecutive cycle. Dropping run clears the count.
// Assumes: LIMIT >= 2.
module lp_cycle_timer #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    assign done = run && (cnt == CW'(LIMIT - 1));

    // Count while run is high; hold at the limit, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!done)     cnt <= cnt + 1'b1;
    end

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT - 1)); // R2
endmodule

// File: rtl/lp_cfg_reg.sv
// Module: configuration register, with the arm, load and cancel logic
// that the sleep pin drives.
// Assumes: in_stby comes from the mode register, and the load events
// come from lp_pin_sense.
module lp_cfg_reg #(
    parameter int          AW        = 22,
    parameter logic [21:0] CFG_RESET = 22'h000010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_stby,
    input  logic          zz_n,
    input  logic          zz_fall,
    input  logic          wr_end,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] cfg_q,
    output logic          load,
    output logic          cancel
);
    logic armed;

    assign load = armed && wr_end && in_stby;

    // Arm on a sleep-pin fall; disarm on a completed write or on wake.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_stby || zz_n) armed <= 1'b0;
        else if (zz_fall)               armed <= 1'b1;
        else if (wr_end)                armed <= 1'b0;
    end

    // Hold the sleep cancel from a load until the pin goes high.
    always_ff @(posedge clk) begin
        if (!rst_n || zz_n) cancel <= 1'b0;
        else if (load)      cancel <= 1'b1;
    end

    // Capture the address bus as the new configuration.
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_q <= AW'(CFG_RESET);
        else if (load) cfg_q <= addr;
    end

    AST_CFG_HELD_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_stby |=> $stable(cfg_q)); // R10
endmodule

// File: rtl/lp_mode_fsm.sv
// Module: mode state machine for standby, partial refresh, deep
// power-down and initializing.
// Assumes: the done inputs are single-cycle qualified by the timers.
module lp_mode_fsm
    import psram_lp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     zz_n,
    input  logic     sleep_done,
    input  logic     init_done,
    input  logic     load,
    input  logic     sleep_sel,
    output lp_mode_e mode
);
    lp_mode_e nxt;

    // Next-state choice; a config load takes priority over sleep entry.
    always_comb begin
        nxt = mode;
        unique case (mode)
            LP_STBY: if (sleep_done && !load) nxt = sleep_sel ? LP_PAR : LP_DPD;
            LP_PAR:  if (zz_n) nxt = LP_STBY;
            LP_DPD:  if (zz_n) nxt = LP_INIT;
            LP_INIT: if (init_done) nxt = LP_STBY;
            default: nxt = LP_STBY;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= LP_STBY;
        else        mode <= nxt;
    end

    AST_PAR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LP_PAR && zz_n) |=> mode == LP_STBY); // R5
    AST_DPD_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LP_DPD && zz_n) |=> mode == LP_INIT); // R6
    AST_LOAD_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> mode == LP_STBY); // R9
endmodule

// File: rtl/psram_sleep_ctrl.sv
// Module: top of the PSRAM low-power controller. It wires pin sensing,
// the two cycle timers, the configuration register and the mode FSM,
// and it keeps the data-lost flag.
// Assumes: all pins are synchronous to clk; timings are given in cycles.
module psram_sleep_ctrl
    import psram_lp_pkg::*;
#(
    parameter int          AW           = 22,
    parameter int          SLEEP_BIT    = 4,
    parameter int          SLEEP_CYCLES = 2000,
    parameter int          INIT_CYCLES  = 30000,
    parameter logic [21:0] CFG_RESET    = 22'h000010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zz_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] cfg_q,
    output logic [1:0]    mode,
    output logic          access_en,
    output logic          data_lost
);
    lp_mode_e st;
    logic zz_fall, wr_now, wr_end;
    logic sleep_done, init_done, load, cancel;
    logic in_stby;

    assign in_stby   = (st == LP_STBY);
    assign mode      = st;
    assign access_en = in_stby;

    lp_pin_sense u_sense (
        .clk(clk), .rst_n(rst_n), .zz_n(zz_n), .ce_n(ce_n), .we_n(we_n),
        .zz_fall(zz_fall), .wr_now(wr_now), .wr_end(wr_end)
    );

    lp_cycle_timer #(.LIMIT(SLEEP_CYCLES)) u_sleep_tmr (
        .clk(clk), .rst_n(rst_n),
        .run(in_stby && !zz_n && !cancel), .done(sleep_done)
    );

    lp_cycle_timer #(.LIMIT(INIT_CYCLES)) u_init_tmr (
        .clk(clk), .rst_n(rst_n), .run(st == LP_INIT), .done(init_done)
    );

    lp_cfg_reg #(.AW(AW), .CFG_RESET(CFG_RESET)) u_cfg (
        .clk(clk), .rst_n(rst_n), .in_stby(in_stby), .zz_n(zz_n),
        .zz_fall(zz_fall), .wr_end(wr_end), .addr(addr),
        .cfg_q(cfg_q), .load(load), .cancel(cancel)
    );

    lp_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .zz_n(zz_n), .sleep_done(sleep_done),
        .init_done(init_done), .load(load), .sleep_sel(cfg_q[SLEEP_BIT]),
        .mode(st)
    );

    // Flag lost contents from deep power-down until the first standby write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 data_lost <= 1'b0;
        else if (st == LP_DPD)      data_lost <= 1'b1;
        else if (in_stby && wr_now) data_lost <= 1'b0;
    end

    AST_PAR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        st == LP_PAR |-> cfg_q[SLEEP_BIT]); // R3
    AST_DPD_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        st == LP_DPD |-> !cfg_q[SLEEP_BIT]); // R3
    AST_LOST_AFTER_DPD: assert property (@(posedge clk) disable iff (!rst_n)
        st == LP_DPD |=> data_lost); // R7
endmodule

// File: tb/tb_psram_sleep_ctrl.sv
// Scoreboard bench: the driver pushes expected outputs into a queue,
// and the monitor pops and compares them on the next falling edge.
module tb_psram_sleep_ctrl;
    localparam int SLP  = 20;
    localparam int INI  = 40;
    localparam logic [21:0] DEF = 22'h000010;

    typedef struct {
        string       tag;
        logic [1:0]  mode;
        logic [21:0] cfg;
        logic        acc;
        logic        lost;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic zz_n = 1'b1, ce_n = 1'b1, we_n = 1'b1;
    logic [21:0] addr = '0;
    logic [21:0] cfg_q;
    logic [1:0]  mode;
    logic        access_en, data_lost;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done_flag = 1'b0;
    exp_t q[$];
    logic [21:0] cfg_m = DEF;
    logic        lost_m = 1'b0;

    always #2.5 clk = ~clk;

    psram_sleep_ctrl #(.SLEEP_CYCLES(SLP), .INIT_CYCLES(INI), .CFG_RESET(DEF)) dut (
        .clk(clk), .rst_n(rst_n), .zz_n(zz_n), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .cfg_q(cfg_q), .mode(mode), .access_en(access_en),
        .data_lost(data_lost)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [1:0] m);
        exp_t e;
        e.tag = tag; e.mode = m; e.cfg = cfg_m;
        e.acc = (m == 2'b00); e.lost = lost_m;
        q.push_back(e);
    endtask

    // Monitor: compare every queued expectation on the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (mode !== e.mode || cfg_q !== e.cfg || access_en !== e.acc || data_lost !== e.lost) begin
                errors++;
                $display("FAIL %s: got mode=%b cfg=%h acc=%b lost=%b, expected mode=%b cfg=%h acc=%b lost=%b",
                         e.tag, mode, cfg_q, access_en, data_lost, e.mode, e.cfg, e.acc, e.lost);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done_flag) begin
            done_flag = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        expect_out("R1 reset state", 2'b00);

        // R2: a short low pulse does not enter sleep.
        zz_n = 1'b0; step(10); zz_n = 1'b1; step(2);
        expect_out("R2 short pulse stays standby", 2'b00);

        // R2/R3/R4: enter partial refresh with the default select bit set.
        zz_n = 1'b0; step(SLP - 1);
        expect_out("R2 not yet asleep", 2'b00);
        step(1);
        expect_out("R3 R4 partial refresh entered", 2'b01);
        // R10: a write while asleep is ignored.
        ce_n = 1'b0; we_n = 1'b0; addr = 22'h3ABCDE; step(2);
        ce_n = 1'b1; we_n = 1'b1; step(1);
        expect_out("R10 R4 write ignored in partial refresh", 2'b01);
        zz_n = 1'b1; step(1);
        expect_out("R5 immediate wake", 2'b00);
        step(2);

        // R8: configuration load after a fall; then R9 cancel.
        zz_n = 1'b0; step(2);
        ce_n = 1'b0; we_n = 1'b0; addr = 22'h02A5E0; step(2);
        we_n = 1'b1; step(1);
        cfg_m = 22'h02A5E0;
        expect_out("R8 config loaded on strobe rise", 2'b00);
        ce_n = 1'b1; step(SLP + 20);
        expect_out("R9 sleep entry cancelled", 2'b00);
        ce_n = 1'b0; we_n = 1'b0; addr = 22'h111111; step(1);
        ce_n = 1'b1; we_n = 1'b1; step(1);
        expect_out("R10 second write not a load", 2'b00);
        zz_n = 1'b1; step(2);

        // R10: a write without a preceding fall does not load.
        ce_n = 1'b0; we_n = 1'b0; addr = 22'h0ABCDE; step(1);
        ce_n = 1'b1; we_n = 1'b1; step(1);
        expect_out("R10 plain write not a load", 2'b00);

        // R3/R6/R7: deep power-down (select bit now 0).
        zz_n = 1'b0; step(SLP);
        lost_m = 1'b0;
        expect_out("R3 R4 deep power-down entered", 2'b10);
        zz_n = 1'b1; step(1);
        lost_m = 1'b1;
        expect_out("R6 R7 initializing", 2'b11);
        step(INI - 1);
        expect_out("R6 still initializing", 2'b11);
        step(1);
        expect_out("R6 R7 back to standby, lost held", 2'b00);
        ce_n = 1'b0; we_n = 1'b0; addr = 22'h000000; step(1);
        lost_m = 1'b0;
        expect_out("R7 first write clears lost flag", 2'b00);
        ce_n = 1'b1; we_n = 1'b1; step(2);

        // R9: load completes on the same edge as timer expiry.
        zz_n = 1'b0; step(1);
        ce_n = 1'b0; we_n = 1'b0; addr = 22'h155550; step(SLP - 2);
        we_n = 1'b1; step(1);
        cfg_m = 22'h155550;
        expect_out("R9 collision: load wins", 2'b00);
        ce_n = 1'b1; step(5);
        expect_out("R9 collision: standby held", 2'b00);
        zz_n = 1'b1; step(3);

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule